// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with One or Two Channels

This block generates one or two independent pulse-width modulated outputs from a single input clock. Each channel runs two counters in a chain. A prescale counter divides the clock by a programmable factor. Every prescaled tick then advances a period counter. The output is high at the start of each period for a programmable number of ticks, and low for the rest of the period.

Software programs each channel through a small synchronous write bus with a combinational read port. Each channel has three registers: a control word, a duty word and a period word. A per-channel enable input starts and stops the waveform. While a channel is running, new settings take effect only at the next period boundary. A control bit chooses how the channel stops: either at the end of the current period, or at once. A build parameter selects one or two channels. The second channel's register set sits 0x10 above the first one's.

Top module: `prescaled_pwm`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and every PWM output is low.
- R2: Register layout per channel. Byte offset 0x00 holds the control word: the prescale value in bits [5:0] and the immediate-stop bit in bit 6. Offset 0x04 holds the duty word: the duty count DC in bits [9:0] and the full-duty flag in bit 10. Offset 0x08 holds the period value PV in bits [9:0]. Bits outside these fields read zero, and offset 0x0C reads zero. Channel 1 uses the same layout, 0x10 higher (bus address bit 4 selects the channel).
- R3: A running channel repeats with a period of (P+1)*(PV+1) input clocks, where P is the prescale value.
- R4: The output is high for the first (P+1)*DC input clocks of each period and low for the rest. When DC is 0, the output stays low.
- R5: When the full-duty flag is set, the output stays high for the whole period, whatever DC holds.
- R6: When DC is at least PV+1, the output stays high for the whole period.
- R7: Duty, period and prescale values written while a channel runs are used from the next period boundary on. The period in progress finishes with the old values.
- R8: When the immediate-stop bit is 0 and the enable input drops, the current period completes and the output is then held low.
- R9: When the immediate-stop bit is 1 and the enable input drops, the output is low from the next clock on.
- R10: In a one-channel build, writes to addresses 0x10 and above have no effect, and those addresses read zero.
- R11: Two channels run at the same time with different settings, and neither disturbs the other's waveform.
- R12: When an enable input rises on an idle channel, the first period starts on the next clock edge, with the output high at once if the duty is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| chan_en | input | NUM_CH (2) | Per-channel run enable |
| pwm_out | output | NUM_CH (2) | Per-channel PWM waveform |

## Verification
The bench sweeps small prescale, period and duty values. It compares every clock of two whole periods against the expected waveform, which exposes an off-by-one in either counter: a wrong terminal count stretches or shrinks the period, and a wrong duty comparison adds or drops one prescaled tick of high time. The edge values DC=0, DC equal to PV+1, DC beyond PV+1 and the full-duty flag each get a check, because a design that handles them wrongly shows a single glitch per period or a stuck-low output. Mid-period rewrites and both stop modes are also checked. A design that reloads its settings at once truncates a pulse, and one that mixes up the stop modes cuts a period short or runs one period too long. A one-channel build is checked for aliasing of the upper bank onto the lower one.

// File: rtl/pwm_ctl_pkg.sv
// Shared constants and types for the prescaled PWM block.
// Assumes the prescale field sits directly below the immediate-stop bit.
package pwm_ctl_pkg;
    localparam int PRESC_W  = 6;
    localparam int PER_W    = 10;
    localparam int STOP_BIT = 6;
    localparam int FULL_BIT = 10;
    localparam int BANK_LSB = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DUTY = 2'd1,
        REG_PER  = 2'd2,
        REG_GAP  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               stop_now;
        logic [PER_W-1:0]   dc;
        logic               full;
        logic [PER_W-1:0]   pv;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_ctl_regs.sv
// Register banks for all channels. Decodes the word address, stores the
// fields of each channel and returns them combinationally on reads.
// Assumes ADDR_W > BANK_LSB. A bank index at or above NUM_CH is unmapped.
module pwm_ctl_regs
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ch_cfg_t           cfg_o [NUM_CH]
);
    localparam int BANK_W = ADDR_W - BANK_LSB;

    logic [BANK_W-1:0] bank;
    reg_sel_e          rsel;
    logic              unused_bits;

    assign bank        = addr[ADDR_W-1:BANK_LSB];
    assign rsel        = reg_sel_e'(addr[BANK_LSB-1:2]);
    assign unused_bits = ^{wdata[DATA_W-1:FULL_BIT+1], addr[1:0]};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
        logic hit;
        assign hit = wr_en && (bank == BANK_W'(ch));

        // Store the fields of the selected register of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[ch] <= '0;
            end else if (hit) begin
                case (rsel)
                    REG_CTRL: begin
                        cfg_o[ch].presc    <= wdata[PRESC_W-1:0];
                        cfg_o[ch].stop_now <= wdata[STOP_BIT];
                    end
                    REG_DUTY: begin
                        cfg_o[ch].dc   <= wdata[PER_W-1:0];
                        cfg_o[ch].full <= wdata[FULL_BIT];
                    end
                    REG_PER:  cfg_o[ch].pv <= wdata[PER_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    // Return the addressed register, zero for the gap and for absent banks.
    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (bank == BANK_W'(ch)) begin
                case (rsel)
                    REG_CTRL: begin
                        rdata[PRESC_W-1:0] = cfg_o[ch].presc;
                        rdata[STOP_BIT]    = cfg_o[ch].stop_now;
                    end
                    REG_DUTY: begin
                        rdata[PER_W-1:0] = cfg_o[ch].dc;
                        rdata[FULL_BIT]  = cfg_o[ch].full;
                    end
                    REG_PER:  rdata[PER_W-1:0] = cfg_o[ch].pv;
                    default:  ;
                endcase
            end
        end
    end

    // R2: the gap word after the period register always reads zero.
    p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == REG_GAP) |-> (rdata == '0));

    // R10: a bank with no channel behind it reads zero.
    p_absent_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bank) >= NUM_CH) |-> (rdata == '0));
endmodule

// File: rtl/pwm_ctl_chan.sv
// One PWM channel: a prescale counter feeding a period counter. Active
// settings are captured at start and at every period boundary. The output
// is high while the period count is below the duty count, or always when
// the full-duty flag is set. Assumes cfg_i holds the live register values.
module pwm_ctl_chan
    import pwm_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_i,
    input  ch_cfg_t cfg_i,
    output logic    pwm_o
);
    logic               running;
    logic [PRESC_W-1:0] pc;
    logic [PER_W-1:0]   cnt;
    logic [PRESC_W-1:0] act_presc;
    logic [PER_W-1:0]   act_dc;
    logic [PER_W-1:0]   act_pv;
    logic               act_full;
    logic               tick;
    logic               wrap;

    assign tick = (pc == act_presc);
    assign wrap = tick && (cnt == act_pv);

    // Run control, the counter chain and reload of the active settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            pc        <= '0;
            cnt       <= '0;
            act_presc <= '0;
            act_dc    <= '0;
            act_pv    <= '0;
            act_full  <= 1'b0;
        end else if (!running) begin
            if (en_i) begin
                running   <= 1'b1;
                pc        <= '0;
                cnt       <= '0;
                act_presc <= cfg_i.presc;
                act_dc    <= cfg_i.dc;
                act_pv    <= cfg_i.pv;
                act_full  <= cfg_i.full;
            end
        end else if (!en_i && cfg_i.stop_now) begin
            running <= 1'b0;
        end else if (tick) begin
            pc <= '0;
            if (wrap) begin
                cnt       <= '0;
                act_presc <= cfg_i.presc;
                act_dc    <= cfg_i.dc;
                act_pv    <= cfg_i.pv;
                act_full  <= cfg_i.full;
                if (!en_i) running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            pc <= pc + 1'b1;
        end
    end

    // Drive the waveform from the period count and the active duty.
    always_comb pwm_o = running && (act_full || (cnt < act_dc));

    // R3: the counters stay within their active limits.
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((cnt <= act_pv) && (pc <= act_presc)));

    // R7: the active settings change only at a period boundary.
    p_hold_settings_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !wrap) |=> ($stable(act_dc) && $stable(act_pv) && $stable(act_full)));

    // R8: a graceful stop keeps the channel running until the boundary.
    p_graceful_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !en_i && !cfg_i.stop_now && !wrap) |=> running);

    // R9: an immediate stop takes the output low on the next clock.
    p_abrupt_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !en_i && cfg_i.stop_now) |=> !pwm_o);
endmodule

// File: rtl/prescaled_pwm.sv
// Top level of the PWM block: register banks plus one counter chain per
// channel. NUM_CH selects a one- or two-channel build. Assumes ADDR_W is
// wide enough for one 16-byte bank per channel.
module prescaled_pwm
    import pwm_ctl_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] pwm_out
);
    ch_cfg_t cfg [NUM_CH];

    pwm_ctl_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwm_ctl_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (chan_en[ch]),
            .cfg_i (cfg[ch]),
            .pwm_o (pwm_out[ch])
        );
    end
endmodule

// File: tb/tb_prescaled_pwm.sv
`timescale 1ns/1ps
module tb_prescaled_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  en = '0;
    logic [1:0]  pout;
    logic        s_wr = 1'b0;
    logic [4:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        s_en = 1'b0;
    logic        s_out;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    prescaled_pwm #(.NUM_CH(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .chan_en(en), .pwm_out(pout));

    prescaled_pwm #(.NUM_CH(1)) dut_single (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(s_wr), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .chan_en(s_en), .pwm_out(s_out));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); addr = a; #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    function automatic bit exp_lvl(input int k, input int t, input int h);
        return (k % t) < h;
    endfunction

    // Program channel 0 (immediate stop set), run two periods, compare each clock.
    task automatic sweep_one(input int p, input int pv, input int dc, input bit full);
        int t, h, bad, bad_k;
        bit got, want;
        t = (p + 1) * (pv + 1);
        h = full ? t : (p + 1) * ((dc < pv + 1) ? dc : pv + 1);
        wr_reg(5'h00, 32'h40 | p);
        wr_reg(5'h04, (full ? 32'h400 : 32'h0) | dc);
        wr_reg(5'h08, pv);
        @(negedge clk); en[0] = 1'b1;
        bad = 0; bad_k = -1; got = 0; want = 0;
        for (int k = 0; k < 2 * t; k++) begin
            @(negedge clk);
            if (pout[0] != exp_lvl(k, t, h) && bad == 0) begin
                bad = 1; bad_k = k; got = pout[0]; want = exp_lvl(k, t, h);
            end
        end
        // R3 R4 R5 R6 R12: whole waveform for this setting
        check(bad == 0, $sformatf("R3/R4/R5/R6/R12 p=%0d pv=%0d dc=%0d full=%0d k=%0d",
              p, pv, dc, full, bad_k), got, want);
        en[0] = 1'b0;
        @(negedge clk);
        check(pout[0] == 1'b0, "R9 low after stop in sweep", pout[0], 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 32; a += 4) rd_check(a[4:0], 32'h0, "R1 reset register");
        check(pout == 2'b00 && s_out == 1'b0, "R1 outputs low", {pout, s_out}, 0);

        // R2: field masks, gap word and channel 1 offset
        wr_reg(5'h00, 32'hFFFF_FFFF); wr_reg(5'h04, 32'hFFFF_FFFF);
        wr_reg(5'h08, 32'hFFFF_FFFF); wr_reg(5'h0C, 32'hFFFF_FFFF);
        rd_check(5'h00, 32'h7F, "R2 ctrl mask");
        rd_check(5'h04, 32'h7FF, "R2 duty mask");
        rd_check(5'h08, 32'h3FF, "R2 period mask");
        rd_check(5'h0C, 32'h0, "R2 gap word");
        rd_check(5'h10, 32'h0, "R2 channel 1 untouched");
        wr_reg(5'h14, 32'h123);
        rd_check(5'h14, 32'h123, "R2 channel 1 duty");
        rd_check(5'h04, 32'h7FF, "R2 channel 0 duty kept");
        for (int a = 0; a < 32; a += 4) wr_reg(a[4:0], 32'h0);

        // R10: one-channel build ignores the upper bank
        @(negedge clk); s_wr = 1'b1; s_addr = 5'h14; s_wdata = 32'h3FF;
        @(negedge clk); s_addr = 5'h04; s_wdata = 32'h5;
        @(negedge clk); s_wr = 1'b0; s_addr = 5'h14; #1;
        check(s_rdata == 0, "R10 upper bank reads zero", s_rdata, 0);
        s_addr = 5'h04; #1;
        check(s_rdata == 32'h5, "R10 lower bank not aliased", s_rdata, 5);

        // R3 R4 R5 R6: sweep
        for (int pi = 0; pi < 3; pi++) begin
            for (int vi = 0; vi < 4; vi++) begin
                int p, pv;
                p = (pi == 2) ? 3 : pi;
                pv = (vi == 3) ? 5 : vi;
                for (int dc = 0; dc <= pv + 2; dc++) sweep_one(p, pv, dc, 1'b0);
                sweep_one(p, pv, 0, 1'b1);
            end
        end

        // R7: duty rewrite mid-period takes effect at the boundary
        begin
            int bad = 0;
            wr_reg(5'h00, 32'h40); wr_reg(5'h04, 2); wr_reg(5'h08, 9);
            @(negedge clk); en[0] = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pout[0] != ((k < 10) ? (k < 2) : (k - 10 < 7))) bad++;
                if (k == 4) begin wr = 1'b1; addr = 5'h04; wdata = 7; end
                if (k == 5) wr = 1'b0;
            end
            check(bad == 0, "R7 duty change at boundary", bad, 0);
            en[0] = 1'b0; @(negedge clk);
        end

        // R7: period rewrite mid-period takes effect at the boundary
        begin
            int bad = 0;
            wr_reg(5'h04, 3); wr_reg(5'h08, 7);
            @(negedge clk); en[0] = 1'b1;
            for (int k = 0; k < 13; k++) begin
                @(negedge clk);
                if (pout[0] != ((k < 8) ? (k < 3) : ((k - 8) % 5 < 3))) bad++;
                if (k == 2) begin wr = 1'b1; addr = 5'h08; wdata = 4; end
                if (k == 3) wr = 1'b0;
            end
            check(bad == 0, "R7 period change at boundary", bad, 0);
            en[0] = 1'b0; @(negedge clk);
        end

        // R8: graceful stop finishes the period
        begin
            int bad = 0;
            wr_reg(5'h00, 32'h0); wr_reg(5'h04, 32'h400); wr_reg(5'h08, 7);
            @(negedge clk); en[0] = 1'b1;
            for (int k = 0; k < 14; k++) begin
                @(negedge clk);
                if (pout[0] != (k < 8)) bad++;
                if (k == 2) en[0] = 1'b0;
            end
            check(bad == 0, "R8 graceful stop", bad, 0);
        end

        // R9: immediate stop
        begin
            int bad = 0;
            wr_reg(5'h00, 32'h40);
            @(negedge clk); en[0] = 1'b1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (pout[0] != (k < 3)) bad++;
                if (k == 2) en[0] = 1'b0;
            end
            check(bad == 0, "R9 immediate stop", bad, 0);
        end

        // R11: both channels concurrently with different settings
        begin
            int bad0 = 0, bad1 = 0;
            wr_reg(5'h00, 32'h40); wr_reg(5'h04, 2); wr_reg(5'h08, 4);
            wr_reg(5'h10, 32'h41); wr_reg(5'h14, 1); wr_reg(5'h18, 2);
            @(negedge clk); en = 2'b11;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (pout[0] != exp_lvl(k, 5, 2)) bad0++;
                if (pout[1] != exp_lvl(k, 6, 2)) bad1++;
            end
            check(bad0 == 0, "R11 channel 0 waveform", bad0, 0);
            check(bad1 == 0, "R11 channel 1 waveform", bad1, 0);
            en = 2'b00; @(negedge clk);
            check(pout == 2'b00, "R9 both stopped", pout, 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule